// File: doc/BRIEF.md
# Parallel Multi-Lane Oscillator Mixer

This block moves a real, time-interleaved sample stream down to baseband. On each accepted clock cycle it takes a group of consecutive samples, one per lane, and multiplies each by a complex local-oscillator value. The result is an I and Q pair per lane. Every lane has its own phase accumulator, and all of them are copies of one logical oscillator. Lane `k` starts `k` frequency steps ahead of lane 0. Every lane moves forward by the lane count times the frequency word on each accepted group. Read in lane order and then group order, the outputs therefore carry one continuous tone at the aggregate sample rate.

A frequency word is loaded through a load strobe. The load also restarts every lane accumulator in the same cycle, so the spacing between lanes stays intact. The top bits of each accumulator address a sine table that holds only a quarter wave; the other three quadrants come from folding that quarter. Filtering and decimation are left to the blocks that follow.

Top module: `nco_mix_top`

## Requirements
- R1: After reset, `outValid` is low, every `outI`/`outQ` lane is zero, and the stored frequency word is zero. Groups accepted before any load therefore see a phase of 0, which gives I ≈ sample and Q ≈ 0.
- R2: Counting accepted groups from the most recent load as m = 0, 1, 2, …, lane k of group m uses phase ((m·LANES + k)·F) mod 2^32, where F is the loaded 32-bit word. The table index is phase[31:22].
- R3: For table index i, the oscillator values are c = round(32767·cos(2πi/1024)) and s = round(32767·sin(2πi/1024)). For sample x, the outputs are I = (x·c + 2^14) >>> 15 and Q = (x·(−s) + 2^14) >>> 15, exact to within 1 LSB.
- R4: A cycle with `inValid` low and no load leaves every lane phase unchanged. The group after a gap continues the phase sequence of R2 without a jump.
- R5: Asserting `freqLoad` stores `freqWord` and restarts every lane together. A group that arrives in the same cycle as the load is group m = 0 of the new word. This holds in the middle of a stream too.
- R6: Each accepted group appears on the outputs exactly 3 clock cycles after it is sampled. `outValid` is `inValid` delayed by 3 cycles.
- R7: The word covers the 150 MHz to 450 MHz band at a 1.6 GHz aggregate rate. The band edges are F = 0x18000000 and F = 0x48000000, and both follow R2 and R3.
- R8: No output ever equals −32768. A full-scale input of −32768 at a phase of 0 gives I = −32767.
- R9: While `outValid` is low, `outI` and `outQ` hold the last valid group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| freqLoad | input | 1 | Loads `freqWord` and restarts all lane phases |
| freqWord | input | 32 | Phase increment per aggregate-rate sample |
| inValid | input | 1 | A group of samples is present on `inSamples` |
| inSamples | input | LANES*16 | Signed samples; lane k is at bits [16k+15:16k], and lane 0 is the earliest |
| outValid | output | 1 | A mixed group is present on the outputs |
| outI | output | LANES*16 | Signed in-phase result per lane, packed like `inSamples` |
| outQ | output | LANES*16 | Signed quadrature result per lane, packed like `inSamples` |

## Verification
Several properties are checked on every cycle:
- Adjacent lane accumulators always differ by exactly the active frequency word.
- The accumulators stay still on idle cycles.
- `outValid` trails `inValid` by three cycles.
- No output reaches −32768.

Other behaviour shows up only in the bench's scenarios, which compare each lane's I and Q against values computed from trigonometry. These scenarios cover the absolute phase of each lane, the table folding across quadrants, the sign of Q, the rounding, continuity across input gaps, restarts in the middle of a stream, and the behaviour at the band edges and at full scale.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  localparam int PHASE_W  = 32;
  localparam int SAMPLE_W = 16;
  localparam int LUT_AW   = 10;
  localparam int PROD_W   = 2 * SAMPLE_W;
  localparam int FRAC_SH  = SAMPLE_W - 1;

  typedef struct packed {
    logic               restart;
    logic               advance;
    logic [PHASE_W-1:0] baseInc;
    logic [PHASE_W-1:0] laneStep;
  } ncoCtrlT;
endpackage

// File: rtl/nco_mix_ctrl.sv
module nco_mix_ctrl
  import nco_mix_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               freqLoad,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               inValid,
  output ncoCtrlT            ctrl
);
  logic [PHASE_W-1:0] fwReg;
  logic [PHASE_W-1:0] activeInc;

  always_ff @(posedge clk) begin
    if (!rstN)         fwReg <= '0;
    else if (freqLoad) fwReg <= freqWord;
  end

  assign activeInc = freqLoad ? freqWord : fwReg;

  always_comb begin
    ctrl.restart  = freqLoad;
    ctrl.advance  = inValid;
    ctrl.baseInc  = activeInc;
    ctrl.laneStep = PHASE_W'(activeInc * PHASE_W'(LANES));
  end

  // R5: a stored word changes only through a load
  assert_word_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !freqLoad |=> fwReg == $past(fwReg));
endmodule

// File: rtl/nco_mix_dp.sv
module nco_mix_dp
  import nco_mix_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ncoCtrlT                     ctrl,
  input  logic [LANES*SAMPLE_W-1:0]   inSamples,
  output logic                        outValid,
  output logic [LANES*SAMPLE_W-1:0]   outI,
  output logic [LANES*SAMPLE_W-1:0]   outQ
);
  localparam int QUARTER = 2 ** (LUT_AW - 2);
  localparam int AMP     = 2 ** (SAMPLE_W - 1) - 1;
  localparam int RND     = 2 ** (FRAC_SH - 1);

  function automatic logic signed [SAMPLE_W-1:0] sinEntry(input int i);
    real r;
    r = real'(AMP) * $sin(2.0 * 3.14159265358979 * real'(i) / real'(2 ** LUT_AW));
    return SAMPLE_W'($rtoi(r + 0.5));
  endfunction

  logic signed [SAMPLE_W-1:0] quarterRom [0:QUARTER];
  for (genvar r = 0; r <= QUARTER; r++) begin : g_rom
    assign quarterRom[r] = sinEntry(r);
  end

  function automatic logic signed [SAMPLE_W-1:0] foldSin(input logic [LUT_AW-1:0] idx);
    logic [LUT_AW-2:0] addr;
    logic signed [SAMPLE_W-1:0] mag;
    addr = {1'b0, idx[LUT_AW-3:0]};
    if (idx[LUT_AW-2]) mag = quarterRom[(LUT_AW-1)'(QUARTER) - addr];
    else               mag = quarterRom[addr];
    return idx[LUT_AW-1] ? -mag : mag;
  endfunction

  logic v1, v2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      outValid <= 1'b0;
    end else begin
      v1 <= ctrl.advance;
      v2 <= v1;
      outValid <= v2;
    end
  end

  // R6: fixed three-cycle latency from an accepted group to its output
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |-> ##3 outValid);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.advance |-> ##3 !outValid);

  logic [PHASE_W-1:0] laneAcc [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PHASE_W-1:0]          phaseNow;
    logic [LUT_AW-1:0]           sIdx;
    logic signed [SAMPLE_W-1:0]  loCos, loNegSin, sampleR;
    logic signed [SAMPLE_W-1:0]  sampleIn;
    logic signed [PROD_W-1:0]    prodI, prodQ;
    logic signed [PROD_W:0]      sumI, sumQ;

    assign sampleIn = inSamples[k*SAMPLE_W +: SAMPLE_W];
    assign phaseNow = ctrl.restart ? PHASE_W'(PHASE_W'(k) * ctrl.baseInc) : laneAcc[k];
    assign sIdx     = phaseNow[PHASE_W-1 -: LUT_AW];

    always_ff @(posedge clk) begin
      if (!rstN) laneAcc[k] <= '0;
      else if (ctrl.restart || ctrl.advance)
        laneAcc[k] <= phaseNow + (ctrl.advance ? ctrl.laneStep : '0);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loCos    <= '0;
        loNegSin <= '0;
        sampleR  <= '0;
      end else if (ctrl.advance) begin
        loCos    <= foldSin(sIdx + LUT_AW'(QUARTER));
        loNegSin <= -foldSin(sIdx);
        sampleR  <= sampleIn;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prodI <= '0;
        prodQ <= '0;
      end else if (v1) begin
        prodI <= sampleR * loCos;
        prodQ <= sampleR * loNegSin;
      end
    end

    assign sumI = {prodI[PROD_W-1], prodI} + (PROD_W+1)'(RND);
    assign sumQ = {prodQ[PROD_W-1], prodQ} + (PROD_W+1)'(RND);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outI[k*SAMPLE_W +: SAMPLE_W] <= '0;
        outQ[k*SAMPLE_W +: SAMPLE_W] <= '0;
      end else if (v2) begin
        outI[k*SAMPLE_W +: SAMPLE_W] <= sumI[FRAC_SH +: SAMPLE_W];
        outQ[k*SAMPLE_W +: SAMPLE_W] <= sumQ[FRAC_SH +: SAMPLE_W];
      end
    end

    // R4: idle cycles leave the lane phase untouched
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.restart && !ctrl.advance |=> $stable(laneAcc[k]));

    // R8: rounding never produces the most negative code
    assert_no_min_code_R8: assert property (@(posedge clk) disable iff (!rstN)
      outI[k*SAMPLE_W +: SAMPLE_W] != {1'b1, {(SAMPLE_W-1){1'b0}}} &&
      outQ[k*SAMPLE_W +: SAMPLE_W] != {1'b1, {(SAMPLE_W-1){1'b0}}});

    if (k > 0) begin : g_spacing
      // R2: neighbouring lanes stay one base increment apart
      assert_lane_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.restart |-> laneAcc[k] - laneAcc[k-1] == ctrl.baseInc);
    end
  end
endmodule

// File: rtl/nco_mix_top.sv
module nco_mix_top
  import nco_mix_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       freqLoad,
  input  logic [PHASE_W-1:0]         freqWord,
  input  logic                       inValid,
  input  logic [LANES*SAMPLE_W-1:0]  inSamples,
  output logic                       outValid,
  output logic [LANES*SAMPLE_W-1:0]  outI,
  output logic [LANES*SAMPLE_W-1:0]  outQ
);
  ncoCtrlT ctrl;

  nco_mix_ctrl #(.LANES(LANES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .freqLoad (freqLoad),
    .freqWord (freqWord),
    .inValid  (inValid),
    .ctrl     (ctrl)
  );

  nco_mix_dp #(.LANES(LANES)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .inSamples (inSamples),
    .outValid  (outValid),
    .outI      (outI),
    .outQ      (outQ)
  );
endmodule

// File: tb/test_nco_mix_top.sv
module test_nco_mix_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int SW = 16;
  localparam int QDEPTH = 512;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [31:0] fw;
    logic [31:0] seed;
  } vecT;

  localparam vecT VECS [6] = '{
    '{32'h2AAA_AAAB, 32'd3},
    '{32'h0123_4567, 32'd17},
    '{32'h8000_0000, 32'd5},
    '{32'h4000_0000, 32'd29},
    '{32'h3333_3333, 32'd41},
    '{32'hF0F0_0F0F, 32'd77}
  };

  logic clk = 1'b0;
  logic rstN;
  logic freqLoad;
  logic [31:0] freqWord;
  logic inValid;
  logic [LANES*SW-1:0] inSamples;
  logic outValid;
  logic [LANES*SW-1:0] outI, outQ;

  int checks = 0;
  int fails = 0;
  logic [31:0] curF;
  longint beatIdx;
  int expI [QDEPTH][LANES];
  int expQ [QDEPTH][LANES];
  string expTag [QDEPTH];
  int wrPtr = 0;
  int rdPtr = 0;
  int lastI [LANES];
  int lastQ [LANES];
  bit done = 1'b0;

  nco_mix_top #(.LANES(LANES)) i_nco_mix_top (
    .clk(clk), .rstN(rstN), .freqLoad(freqLoad), .freqWord(freqWord),
    .inValid(inValid), .inSamples(inSamples),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int loRef(input bit useCos, input logic [31:0] ph);
    real a, v, r;
    a = 2.0 * 3.14159265358979 * real'(int'(ph[31:22])) / 1024.0;
    v = useCos ? $cos(a) : $sin(a);
    r = 32767.0 * v;
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int mixRef(input int x, input int lo);
    longint p;
    p = longint'(x) * longint'(lo) + 64'sd16384;
    return int'(p >>> 15);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      freqLoad = 1'b0;
      inValid = 1'b0;
    end
  endtask

  task automatic loadOnly(input logic [31:0] fw);
    @(negedge clk);
    freqLoad = 1'b1;
    freqWord = fw;
    inValid = 1'b0;
    curF = fw;
    beatIdx = 0;
  endtask

  // One group of samples; fullScale != 0 forces every lane to that value.
  task automatic sendBeat(input bit withLoad, input logic [31:0] fw, input int seed,
                          input int fullScale, input string tag);
    @(negedge clk);
    freqLoad = withLoad;
    freqWord = fw;
    if (withLoad) begin
      curF = fw;
      beatIdx = 0;
    end
    for (int l = 0; l < LANES; l++) begin
      longint n;
      logic [31:0] ph;
      int x;
      n = beatIdx * LANES + l;
      ph = 32'(n * longint'(curF));
      if (fullScale != 0) x = fullScale;
      else x = ((seed * 911 + int'(n) * 2749 + l * 331) % 65536) - 32768;
      inSamples[l*SW +: SW] = SW'(x);
      expI[wrPtr % QDEPTH][l] = mixRef(x, loRef(1'b1, ph));
      expQ[wrPtr % QDEPTH][l] = mixRef(x, -loRef(1'b0, ph));
    end
    expTag[wrPtr % QDEPTH] = tag;
    wrPtr++;
    inValid = 1'b1;
    beatIdx++;
  endtask

  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (rdPtr == wrPtr) begin
        check(1'b0, "R6", "unexpected outValid", 1, 0);
      end else begin
        for (int l = 0; l < LANES; l++) begin
          int ai, aq, ei, eq;
          ai = int'($signed(outI[l*SW +: SW]));
          aq = int'($signed(outQ[l*SW +: SW]));
          ei = expI[rdPtr % QDEPTH][l];
          eq = expQ[rdPtr % QDEPTH][l];
          check((ai - ei) <= 1 && (ei - ai) <= 1, expTag[rdPtr % QDEPTH],
                $sformatf("group %0d lane %0d I", rdPtr, l), ai, ei);
          check((aq - eq) <= 1 && (eq - aq) <= 1, expTag[rdPtr % QDEPTH],
                $sformatf("group %0d lane %0d Q", rdPtr, l), aq, eq);
          lastI[l] = ai;
          lastQ[l] = aq;
        end
        rdPtr++;
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    freqLoad = 1'b0;
    freqWord = '0;
    inValid = 1'b0;
    inSamples = '0;
    curF = '0;
    beatIdx = 0;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check(outValid == 1'b0, "R1", "outValid at reset", int'(outValid), 0);
    check(outI == '0 && outQ == '0, "R1", "outputs at reset", int'(outI != '0 || outQ != '0), 0);
    rstN = 1'b1;

    // R1: word is zero before any load
    sendBeat(1'b0, '0, 9, 0, "R1");
    sendBeat(1'b0, '0, 10, 0, "R1");
    idle(5);

    // R2 R3: table of words, first group carries the load
    for (int v = 0; v < 6; v++) begin
      sendBeat(1'b1, VECS[v].fw, int'(VECS[v].seed), 0, "R5");
      for (int b = 0; b < 4; b++) sendBeat(1'b0, '0, int'(VECS[v].seed), 0, "R2/R3");
    end
    idle(6);
    // R9: outputs hold the last group while outValid is low
    for (int l = 0; l < LANES; l++) begin
      check(int'($signed(outI[l*SW +: SW])) == lastI[l], "R9", "held I",
            int'($signed(outI[l*SW +: SW])), lastI[l]);
      check(int'($signed(outQ[l*SW +: SW])) == lastQ[l], "R9", "held Q",
            int'($signed(outQ[l*SW +: SW])), lastQ[l]);
    end

    // R4: gaps between groups do not move the phase
    loadOnly(32'h1234_5678);
    idle(2);
    sendBeat(1'b0, '0, 55, 0, "R4");
    idle(3);
    sendBeat(1'b0, '0, 56, 0, "R4");
    idle(1);
    sendBeat(1'b0, '0, 57, 0, "R4");
    idle(5);

    // R5: reload in the middle of a stream
    sendBeat(1'b1, 32'h0765_4321, 60, 0, "R5");
    sendBeat(1'b0, '0, 61, 0, "R5");
    sendBeat(1'b1, 32'h1F00_00F1, 62, 0, "R5");
    sendBeat(1'b0, '0, 63, 0, "R5");
    sendBeat(1'b0, '0, 64, 0, "R5");
    idle(6);

    // R7: band edges
    sendBeat(1'b1, 32'h1800_0000, 70, 0, "R7");
    for (int b = 0; b < 3; b++) sendBeat(1'b0, '0, 71, 0, "R7");
    sendBeat(1'b1, 32'h4800_0000, 72, 0, "R7");
    for (int b = 0; b < 3; b++) sendBeat(1'b0, '0, 73, 0, "R7");
    idle(6);

    // R8: full-scale inputs at the phases with peak oscillator values
    sendBeat(1'b1, 32'h0000_0000, 0, -32768, "R8");
    sendBeat(1'b1, 32'h8000_0000, 0, -32768, "R8");
    sendBeat(1'b1, 32'h4000_0000, 0, -32768, "R8");
    sendBeat(1'b1, 32'h8000_0000, 0, 32767, "R8");
    idle(6);

    // R6: a single group becomes visible on the third negedge
    sendBeat(1'b1, 32'h0000_0000, 0, -32768, "R8");
    for (int i = 1; i <= 5; i++) begin
      idle(1);
      check(outValid == (i == 3), "R6", $sformatf("outValid at cycle %0d", i),
            int'(outValid), int'(i == 3));
    end
    check(int'($signed(outI[SW-1:0])) == -32767, "R8", "full-scale lane 0 I",
          int'($signed(outI[SW-1:0])), -32767);
    idle(4);
    check(rdPtr == wrPtr, "R6", "all groups emitted", rdPtr, wrPtr);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule